// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a table of message-signalled interrupt vectors and the matching array of pending bits behind a 32-bit register port. It also holds the two control bits of the function: the enable bit and the mask-all bit. Every vector entry stores a 64-bit message address, a 32-bit message data word and a per-vector mask bit. A device-side agent raises interrupt requests by vector number, and it declares which vectors are in use by counting up or down.

A request for a masked vector sets its pending bit. A request for an unmasked vector sends one message write on a request/acknowledge master port. Whenever a vector goes from masked to unmasked while its pending bit is set, the bit is cleared and the message is sent. Messages waiting to go out are sent in ascending vector order. A held request can be followed by the next one in the cycle after an acknowledge.

The sender is a two-state machine. In `SND_IDLE` it waits. The transition `IDLE->BUSY` is taken when any vector is ready to send; that vector's address and data are latched in the same cycle. In `SND_BUSY` the request is held. On acknowledge, the transition `BUSY->BUSY` loads the next ready vector and `BUSY->IDLE` is taken when no vector is ready.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, both control bits read 0, no message request is raised, the pending word reads 0, and every table word reads 0 except each vector-control word, which reads 1.
- R2: Entry n lives at byte offset 16*n. Its words are: address low at +0, address high at +4, data at +8, and vector control at +12. Vector control holds the mask in bit 0, and its other bits read 0. Entries at or above NUM_VEC read 0, and writes to them change nothing.
- R3: The pending array is a read-only word at offset 0x800, with bit n for vector n. Writes to it are ignored.
- R4: The function mask is (enable==0) OR mask-all. A vector is masked when the function mask is set or its own mask bit is set. While the function mask is set, no new message is started.
- R5: A request for an in-range vector with a non-zero in-use count that is masked sets that vector's pending bit and sends no message.
- R6: A request for an in-range, in-use, unmasked vector sends exactly one message. Its address is {high word, low word} and its data is the entry's data word.
- R7: A request for a vector at or above NUM_VEC, or for a vector whose in-use count is zero, is discarded and sets no pending bit.
- R8: When a vector goes from masked to unmasked with its pending bit set, the bit is cleared and the vector's message is sent.
- R9: Vectors waiting to send go out in ascending vector order, one handshake per cycle while acknowledge stays high. A request for a vector that is already waiting merges into the waiting send.
- R10: msg_req stays high, with msg_addr and msg_data stable, until msg_ack is seen.
- R11: use_inc raises a vector's in-use count, saturating at the maximum. use_dec lowers it. Lowering the count to zero clears the vector's pending bit. use_dec on a count of zero has no effect.
- R12: A vector that is waiting to send but becomes masked before it is sent turns into a pending bit instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address in the 4 KiB window (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_enable_in | input | 1 | New enable bit |
| ctl_maskall_in | input | 1 | New mask-all bit |
| ctl_enable | output | 1 | Current enable bit |
| ctl_maskall | output | 1 | Current mask-all bit |
| int_req | input | 1 | Interrupt request strobe |
| int_vec | input | 5 | Requested vector number |
| use_inc | input | 1 | Raise the in-use count of use_vec |
| use_dec | input | 1 | Lower the in-use count of use_vec |
| use_vec | input | 5 | Vector for the in-use count update |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_ack | input | 1 | Message write accepted |

## Verification
The bench goes after these corners:
- Entry 8 aliasing entry 0 through truncated index bits. A design with this fault would corrupt vector 0's address on an out-of-range write.
- A count that wraps when decremented below zero. Such a design would drop a later request after a single increment.
- Replay order after mask-all is cleared. A wrong priority encoder would emit vectors 1, 5 and 6 out of order, or with gaps between handshakes.
- A second request while acknowledge is held low must merge. A design that replays it on its own would send an extra message.
- A waiting vector that is masked must come back as a pending bit. Otherwise the design would lose it or send it while masked.

// File: rtl/msix_pkg.sv
package msix_pkg;
    localparam int MAX_VEC = 32;
    localparam int VNUM_W  = 5;

    typedef enum logic [0:0] {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;
endpackage

// File: rtl/msix_table.sv
module msix_table #(
    parameter int NUM_VEC = 8,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [11:0]        addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] vmask,
    input  logic [IW-1:0]      sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data
);
    logic [31:0] lo_q  [NUM_VEC];
    logic [31:0] hi_q  [NUM_VEC];
    logic [31:0] dat_q [NUM_VEC];
    logic [NUM_VEC-1:0] vm_q;

    logic          in_table;
    logic [IW-1:0] eidx;

    assign in_table = !addr[11] && (32'(addr[10:4]) < NUM_VEC);
    assign eidx     = addr[4 +: IW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                dat_q[i] <= '0;
            end
            vm_q <= '1;
        end else if (wr_en && in_table) begin
            unique case (addr[3:2])
                2'd0: lo_q[eidx]  <= wdata;
                2'd1: hi_q[eidx]  <= wdata;
                2'd2: dat_q[eidx] <= wdata;
                2'd3: vm_q[eidx]  <= wdata[0];
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (in_table) begin
            unique case (addr[3:2])
                2'd0: rdata = lo_q[eidx];
                2'd1: rdata = hi_q[eidx];
                2'd2: rdata = dat_q[eidx];
                2'd3: rdata = {31'd0, vm_q[eidx]};
            endcase
        end else if (addr[11] && addr[10:2] == '0) begin
            rdata = 32'(pend);
        end
    end

    assign vmask    = vm_q;
    assign sel_addr = {hi_q[sel_idx], lo_q[sel_idx]};
    assign sel_data = dat_q[sel_idx];
endmodule

// File: rtl/msix_vec_state.sv
module msix_vec_state #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [4:0]         req_vec,
    input  logic               use_inc,
    input  logic               use_dec,
    input  logic [4:0]         use_vec,
    input  logic [NUM_VEC-1:0] vmasked,
    input  logic               issue,
    input  logic [IW-1:0]      issue_idx,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] queued,
    output logic [NUM_VEC-1:0] unused
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        localparam logic [4:0] VID = 5'(v);

        logic [CNT_W-1:0] cnt_q, cnt_n;
        logic             p_q, p_n, q_q, q_n, mq_q;
        logic             hit, inc, dec;

        assign hit = req && (req_vec == VID) && (cnt_q != '0);
        assign inc = use_inc && !use_dec && (use_vec == VID);
        assign dec = use_dec && !use_inc && (use_vec == VID);

        always_comb begin
            cnt_n = cnt_q;
            if (inc && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
            if (dec && cnt_q != '0)      cnt_n = cnt_q - 1'b1;
            p_n = p_q;
            q_n = q_q;
            if (mq_q && !vmasked[v] && p_q) begin
                p_n = 1'b0;
                q_n = 1'b1;
            end
            if (issue && issue_idx == IW'(v)) q_n = 1'b0;
            if (vmasked[v] && q_n) begin
                q_n = 1'b0;
                p_n = 1'b1;
            end
            if (hit) begin
                if (vmasked[v]) p_n = 1'b1;
                else            q_n = 1'b1;
            end
            if (dec && cnt_q == CNT_W'(1)) begin
                p_n = 1'b0;
                q_n = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
                p_q   <= 1'b0;
                q_q   <= 1'b0;
                mq_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_n;
                p_q   <= p_n;
                q_q   <= q_n;
                mq_q  <= vmasked[v];
            end
        end

        assign pend[v]   = p_q;
        assign queued[v] = q_q;
        assign unused[v] = (cnt_q == '0);
    end
endmodule

// File: rtl/msix_sender.sv
module msix_sender
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] ready,
    input  logic [63:0]        sel_addr,
    input  logic [31:0]        sel_data,
    input  logic               msg_ack,
    output logic [IW-1:0]      pick_idx,
    output logic               issue,
    output logic               msg_req,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    snd_state_e state_q, state_n;
    logic       any;
    logic [63:0] addr_q;
    logic [31:0] data_q;

    always_comb begin
        pick_idx = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (ready[i]) pick_idx = IW'(i);
        end
    end
    assign any = |ready;

    always_comb begin
        state_n = state_q;
        issue   = 1'b0;
        unique case (state_q)
            SND_IDLE: begin
                if (any) begin
                    issue   = 1'b1;
                    state_n = SND_BUSY;
                end
            end
            SND_BUSY: begin
                if (msg_ack) begin
                    issue   = any;
                    state_n = any ? SND_BUSY : SND_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SND_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (issue) begin
            addr_q <= sel_addr;
            data_q <= sel_data;
        end
    end

    assign msg_req  = (state_q == SND_BUSY);
    assign msg_addr = addr_q;
    assign msg_data = data_q;
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ctl_we,
    input  logic        ctl_enable_in,
    input  logic        ctl_maskall_in,
    output logic        ctl_enable,
    output logic        ctl_maskall,
    input  logic        int_req,
    input  logic [4:0]  int_vec,
    input  logic        use_inc,
    input  logic        use_dec,
    input  logic [4:0]  use_vec,
    output logic        msg_req,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    input  logic        msg_ack
);
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic               en_q, ma_q, fmask;
    logic [NUM_VEC-1:0] vmask, vmasked, pend_bits, queued_bits, unused_bits, ready;
    logic [IW-1:0]      pick_idx;
    logic               issue;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ma_q <= 1'b0;
        end else if (ctl_we) begin
            en_q <= ctl_enable_in;
            ma_q <= ctl_maskall_in;
        end
    end

    assign ctl_enable  = en_q;
    assign ctl_maskall = ma_q;
    assign fmask       = !en_q || ma_q;
    assign vmasked     = vmask | {NUM_VEC{fmask}};
    assign ready       = queued_bits & ~vmasked;

    msix_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .pend(pend_bits),
        .vmask(vmask), .sel_idx(pick_idx), .sel_addr(sel_addr),
        .sel_data(sel_data)
    );

    msix_vec_state #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_state (
        .clk(clk), .rst_n(rst_n), .req(int_req), .req_vec(int_vec),
        .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
        .vmasked(vmasked), .issue(issue), .issue_idx(pick_idx),
        .pend(pend_bits), .queued(queued_bits), .unused(unused_bits)
    );

    msix_sender #(.NUM_VEC(NUM_VEC)) u_sender (
        .clk(clk), .rst_n(rst_n), .ready(ready), .sel_addr(sel_addr),
        .sel_data(sel_data), .msg_ack(msg_ack), .pick_idx(pick_idx),
        .issue(issue), .msg_req(msg_req), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_enable,
    input logic               msg_req,
    input logic               msg_ack,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] queued,
    input logic [NUM_VEC-1:0] vmasked,
    input logic [NUM_VEC-1:0] unused
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

    assert_fmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_enable && (!msg_req || msg_ack)) |=> !msg_req);

    assert_pend_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(vmasked)) == '0));

    assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & queued) == '0));

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
        assert_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
            unused[v] |-> (!pend[v] && !queued[v]));
    end
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .msg_req(msg_req),
    .msg_ack(msg_ack), .msg_addr(msg_addr), .msg_data(msg_data),
    .pend(pend_bits), .queued(queued_bits), .vmasked(vmasked),
    .unused(unused_bits)
);

// File: tb/msix_vec_ctrl_test.sv
module msix_vec_ctrl_test;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_we = 1'b0, ctl_enable_in = 1'b0, ctl_maskall_in = 1'b0;
    logic        ctl_enable, ctl_maskall;
    logic        int_req = 1'b0;
    logic [4:0]  int_vec = '0;
    logic        use_inc = 1'b0, use_dec = 1'b0;
    logic [4:0]  use_vec = '0;
    logic        msg_req;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        ack_en = 1'b1;
    logic        msg_ack;

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc = 0;
    int log_n = 0;
    logic [63:0] log_a [64];
    logic [31:0] log_d [64];
    int          log_c [64];

    assign msg_ack = ack_en;
    always #10 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(NV)) uut (.*);

    always @(posedge clk) begin
        cyc++;
        if (msg_req && msg_ack && log_n < 64) begin
            log_a[log_n] = msg_addr;
            log_d[log_n] = msg_data;
            log_c[log_n] = cyc;
            log_n++;
        end
    end

    function automatic logic [31:0] exp_lo(int v); return 32'h4000_0000 | 32'(v << 4); endfunction
    function automatic logic [31:0] exp_hi(int v); return 32'h0000_0100 + 32'(v); endfunction
    function automatic logic [31:0] exp_dt(int v); return 32'hCAFE_0000 + 32'(v); endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic ctl(bit en, bit ma);
        @(negedge clk); ctl_we = 1'b1; ctl_enable_in = en; ctl_maskall_in = ma;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic req(int v);
        @(negedge clk); int_req = 1'b1; int_vec = 5'(v);
        @(negedge clk); int_req = 1'b0;
    endtask

    task automatic use_op(bit up, int v);
        @(negedge clk); use_inc = up; use_dec = !up; use_vec = 5'(v);
        @(negedge clk); use_inc = 1'b0; use_dec = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_pend(logic [31:0] exp, string tag);
        logic [31:0] d;
        rd(12'h800, d);
        chk(d == exp, tag, 64'(d), 64'(exp));
    endtask

    task automatic chk_last(int v, string tag);
        chk(log_n > 0 && log_a[log_n-1] == {exp_hi(v), exp_lo(v)}, {tag, " addr"},
            log_a[log_n-1], {exp_hi(v), exp_lo(v)});
        chk(log_n > 0 && log_d[log_n-1] == exp_dt(v), {tag, " data"},
            64'(log_d[log_n-1]), 64'(exp_dt(v)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(ctl_enable == 0 && ctl_maskall == 0, "R1 ctl bits", 64'({ctl_enable, ctl_maskall}), 0);
        chk(msg_req == 0, "R1 msg_req", 64'(msg_req), 0);
        chk_pend(0, "R1 pend");
        for (int v = 0; v < NV; v++) begin
            for (int w = 0; w < 4; w++) begin
                rd(12'(v * 16 + w * 4), d);
                chk(d == ((w == 3) ? 32'd1 : 32'd0), "R1 table word", 64'(d),
                    (w == 3) ? 64'd1 : 64'd0);
            end
        end

        // R2 program and read back, upper control bits read 0
        for (int v = 0; v < NV; v++) begin
            wr(12'(v * 16 + 0), exp_lo(v));
            wr(12'(v * 16 + 4), exp_hi(v));
            wr(12'(v * 16 + 8), exp_dt(v));
            wr(12'(v * 16 + 12), 32'hFFFF_FFFF);
        end
        for (int v = 0; v < NV; v++) begin
            rd(12'(v * 16 + 0), d);  chk(d == exp_lo(v), "R2 lo", 64'(d), 64'(exp_lo(v)));
            rd(12'(v * 16 + 4), d);  chk(d == exp_hi(v), "R2 hi", 64'(d), 64'(exp_hi(v)));
            rd(12'(v * 16 + 8), d);  chk(d == exp_dt(v), "R2 data", 64'(d), 64'(exp_dt(v)));
            rd(12'(v * 16 + 12), d); chk(d == 32'd1, "R2 ctrl", 64'(d), 1);
        end
        // R2 out-of-range entry write ignored, no alias onto entry 0
        wr(12'h080, 32'hDEAD_BEEF);
        rd(12'h080, d); chk(d == 0, "R2 oor read", 64'(d), 0);
        rd(12'h000, d); chk(d == exp_lo(0), "R2 no alias", 64'(d), 64'(exp_lo(0)));

        // R3 pending array read-only
        wr(12'h800, 32'hFFFF_FFFF);
        chk_pend(0, "R3 pend write ignored");

        // R7 unused vector and out-of-range vector dropped even when masked
        req(2); req(9); idle(4);
        chk_pend(0, "R7 dropped");
        chk(log_n == 0, "R7 no message", 64'(log_n), 0);

        for (int v = 0; v < NV; v++) use_op(1, v);

        // R5 / R4 disabled function masks vector 3
        req(3); idle(4);
        chk_pend(32'h08, "R5 pend set");
        chk(log_n == 0, "R5 no message", 64'(log_n), 0);

        ctl(1, 0); idle(4);
        chk(ctl_enable == 1 && ctl_maskall == 0, "R4 ctl readback", 64'({ctl_enable, ctl_maskall}), 64'd2);
        chk_pend(32'h08, "R4 vector mask still holds");

        // R8 unmask vector 3 replays
        wr(12'h03C, 32'h0); idle(5);
        chk(log_n == 1, "R8 replay count", 64'(log_n), 1);
        chk_last(3, "R8 replay");
        chk_pend(0, "R8 pend cleared");

        // R6 sweep over all vectors unmasked
        for (int v = 0; v < NV; v++) wr(12'(v * 16 + 12), 32'h0);
        idle(3);
        for (int v = 0; v < NV; v++) begin
            base = log_n;
            req(v); idle(4);
            chk(log_n == base + 1, "R6 one message", 64'(log_n), 64'(base + 1));
            chk_last(v, "R6 message");
        end

        // R9 ordered back-to-back replay after mask-all clears
        ctl(1, 1);
        req(6); req(1); req(5); idle(3);
        chk_pend(32'h62, "R9 pend before release");
        base = log_n;
        ctl(1, 0); idle(8);
        chk(log_n == base + 3, "R9 count", 64'(log_n), 64'(base + 3));
        chk(log_d[base] == exp_dt(1) && log_d[base+1] == exp_dt(5) && log_d[base+2] == exp_dt(6),
            "R9 order", {log_d[base][7:0], log_d[base+1][7:0], log_d[base+2][7:0]}, 64'h010506);
        chk(log_c[base+1] == log_c[base] + 1 && log_c[base+2] == log_c[base+1] + 1,
            "R9 back-to-back", 64'(log_c[base+2] - log_c[base]), 2);

        // R11 in-use count on vector 4
        wr(12'h04C, 32'h1);
        req(4); idle(3);
        chk_pend(32'h10, "R11 pend v4");
        use_op(1, 4); use_op(0, 4); idle(1);
        chk_pend(32'h10, "R11 count 1 keeps pend");
        use_op(0, 4); idle(1);
        chk_pend(0, "R11 zero clears pend");
        use_op(0, 4); req(4); idle(2);
        chk_pend(0, "R11 R7 unused drop");
        use_op(1, 4);
        base = log_n;
        wr(12'h04C, 32'h0); idle(4);
        chk(log_n == base, "R11 no replay after clear", 64'(log_n), 64'(base));
        req(4); idle(4);
        chk(log_n == base + 1, "R11 no underflow", 64'(log_n), 64'(base + 1));

        // R10 hold while ack low, R9 merge
        ack_en = 1'b0;
        base = log_n;
        req(0); idle(3);
        chk(msg_req == 1 && msg_addr == {exp_hi(0), exp_lo(0)}, "R10 held",
            msg_addr, {exp_hi(0), exp_lo(0)});
        req(0); req(0); idle(3);
        chk(msg_req == 1 && msg_data == exp_dt(0), "R10 stable data", 64'(msg_data), 64'(exp_dt(0)));
        ack_en = 1'b1; idle(6);
        chk(log_n == base + 2, "R9 merge", 64'(log_n), 64'(base + 2));

        // R12 waiting vector masked becomes pending
        ack_en = 1'b0;
        base = log_n;
        req(0); req(2); idle(2);
        ctl(1, 1); idle(2);
        chk_pend(32'h04, "R12 queued to pend");
        ack_en = 1'b1; idle(3);
        chk(log_n == base + 1, "R12 in-flight completes", 64'(log_n), 64'(base + 1));
        ctl(1, 0); idle(6);
        chk(log_n == base + 2, "R12 replay count", 64'(log_n), 64'(base + 2));
        chk_last(2, "R12 replay");

        // R7 out-of-range while fully unmasked
        base = log_n;
        req(9); idle(4);
        chk(log_n == base, "R7 oor unmasked", 64'(log_n), 64'(base));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule